// File: doc/BRIEF.md
# Cross-Trigger Event Router

This block collects eight single-bit trigger events from a processor core and its trace unit and steers them onto eight trigger outputs. Each output owns a programmable enable mask that selects which inputs may fire it. Each output also has one fixed handshake style:

- **Pulsed outputs** produce a one-cycle strobe for each event.
- **Sticky outputs** stay high until software acknowledges them.
- **The restart output** stays high until the processor reports that it has restarted.

The input roles are fixed:

- Input 0 means the core has halted.
- Inputs 1 to 3 are data-watch comparator hits.
- Inputs 4 to 7 are trace-unit events.

The output roles are fixed:

- Output 0 is the halt (debug) request.
- Outputs 1 and 2 are interrupt requests.
- Outputs 3 to 6 feed trace-unit event inputs.
- Output 7 is the restart request.

A restart may not go out while a halt request is still standing. It waits until the halt request has been acknowledged.

Software programs the block through a plain write port that has a strobe, an address and a data byte. The address map is:

| Address | Function |
|---|---|
| 0 to 7 | Enable mask for output 0 to 7 |
| 8 | Acknowledge |
| 9 | Software fire |

Top module: `xtrig_router`

## Requirements
- R1: A synchronous active-low reset clears all outputs, all enable masks and the pending restart. After reset, input events fire no output until a mask is written.
- R2: Inputs are rising-edge detected. A level held for several cycles counts as one event.
- R3: A write to address n (0 to 7) sets the 8-bit enable mask of output n. Output n fires in a cycle in which any input whose bit is set in that mask rises.
- R4: Outputs 3 to 6 are pulsed. A firing raises the output for exactly the one cycle after the clock edge that samples the input rise.
- R5: Outputs 0 to 2 are sticky. Once fired, they stay high until a write to address 8 has a one in bit n. A write with a zero in bit n leaves output n alone.
- R6: If an event fires a sticky output in the same cycle that its acknowledge bit is written, the output stays high.
- R7: Output 7 does not go high while output 0 is high. A restart fired during that time is held pending, and it appears in the same cycle that output 0 clears.
- R8: Once high, output 7 stays high until `restarted` is sampled high, and it is low from the next cycle. Bits 3 to 7 of an acknowledge write have no effect.
- R9: A write to address 9 fires every output whose data bit is one. That firing follows the same handshake rules as an input event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 8 | Trigger event inputs |
| restarted | input | 1 | Processor restarted handshake |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| trig_out | output | 8 | Trigger outputs |

## Verification
The bench drives a held input level for several cycles. A design without edge detection would repeat the pulse, or keep a pulsed output high. It lands a new event and its acknowledge in the same cycle; a design that let the acknowledge win would drop an interrupt. It requests a restart while the halt request is still high, and then acknowledges the halt. A design with no hold-off would restart a halted core too early, and a design that lost the pending request would never restart it. It also writes acknowledge bits for outputs that are not sticky, which a careless decode would let cancel a restart.

// File: rtl/xtrig_router.sv
module xtrig_router #(
  parameter int ACK_ADDR = 8,
  parameter int SWF_ADDR = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] trig_in,
  input  logic       restarted,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] trig_out
);
  logic [7:0] mask_q [8];
  logic [7:0] prev_q;
  logic [6:0] out_q;
  logic       pend_q;
  logic [7:0] rise, fire, ack, swf;

  assign rise = trig_in & ~prev_q;
  assign ack  = (wr_en && wr_addr == 4'(ACK_ADDR)) ? wr_data : 8'h00;
  assign swf  = (wr_en && wr_addr == 4'(SWF_ADDR)) ? wr_data : 8'h00;

  for (genvar n = 0; n < 8; n++) begin : g_fire
    assign fire[n] = (|(rise & mask_q[n])) | swf[n];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      out_q  <= '0;
      pend_q <= 1'b0;
      for (int i = 0; i < 8; i++) mask_q[i] <= '0;
    end else begin
      prev_q     <= trig_in;
      out_q[2:0] <= fire[2:0] | (out_q[2:0] & ~ack[2:0]);
      out_q[6:3] <= fire[6:3];
      pend_q     <= fire[7] | (pend_q & ~(restarted & ~out_q[0]));
      if (wr_en && !wr_addr[3]) mask_q[wr_addr[2:0]] <= wr_data;
    end
  end

  assign trig_out = {pend_q & ~out_q[0], out_q};

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> trig_out == 8'h00);

  for (genvar s = 0; s < 3; s++) begin : g_sticky_chk
    assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out[s] && !(wr_en && wr_addr == 4'(ACK_ADDR) && wr_data[s]) |=> trig_out[s]);
  end

  assert_restart_holdoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out[0] |-> !trig_out[7]);

  assert_restart_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !restarted |=> pend_q);

  assert_restart_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out[7] && restarted && !fire[7] |=> !trig_out[7]);
endmodule

// File: tb/xtrig_router_tb.sv
module xtrig_router_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] trig_in = '0;
  logic       restarted = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] trig_out;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  xtrig_router dut_i (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .restarted(restarted),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .trig_out(trig_out)
  );

  // {input pattern, expected trig_out[6:3]} with masks 3..6 = 01,0E,F0,81
  localparam logic [11:0] VEC [8] = '{
    {8'h01, 4'b1001}, {8'h02, 4'b0010}, {8'h10, 4'b0100}, {8'h80, 4'b1100},
    {8'h00, 4'b0000}, {8'h0F, 4'b1011}, {8'h60, 4'b0100}, {8'hFF, 4'b1111}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] p);
    @(negedge clk); trig_in = p;
    @(negedge clk); trig_in = '0;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", trig_out, 8'h00);
    @(negedge clk); trig_in = 8'hFF;
    @(negedge clk); chk("R1 masks cleared", trig_out, 8'h00);
    trig_in = '0;
    @(negedge clk);

    wr(4'd3, 8'h01); wr(4'd4, 8'h0E); wr(4'd5, 8'hF0); wr(4'd6, 8'h81);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); trig_in = VEC[i][11:4];
      @(negedge clk);
      chk("R3 R4 routed pulse", trig_out, {1'b0, VEC[i][3:0], 3'b000});
      trig_in = '0;
      @(negedge clk);
      chk("R4 pulse ends", trig_out, 8'h00);
    end

    // R2: held level
    @(negedge clk); trig_in = 8'h02;
    @(negedge clk); chk("R2 first cycle", trig_out, 8'h10);
    @(negedge clk); chk("R2 held no repeat", trig_out, 8'h00);
    @(negedge clk); chk("R2 held no repeat", trig_out, 8'h00);
    trig_in = '0;
    wr(4'd3, 8'h00); wr(4'd4, 8'h00); wr(4'd5, 8'h00); wr(4'd6, 8'h00);

    // R5: sticky
    wr(4'd0, 8'h01); wr(4'd1, 8'h02); wr(4'd2, 8'h04);
    pulse(8'h01);
    chk("R5 sticky set", trig_out, 8'h01);
    repeat (3) @(negedge clk);
    chk("R5 sticky holds", trig_out, 8'h01);
    wr(4'd8, 8'h02);
    chk("R5 other ack bit ignored", trig_out, 8'h01);
    wr(4'd8, 8'h01);
    chk("R5 ack clears", trig_out, 8'h00);

    // R6: event beats ack
    pulse(8'h02);
    chk("R6 irq set", trig_out, 8'h02);
    @(negedge clk); trig_in = 8'h02; wr_en = 1'b1; wr_addr = 4'd8; wr_data = 8'h02;
    @(negedge clk); trig_in = '0; wr_en = 1'b0;
    chk("R6 event wins", trig_out, 8'h02);
    wr(4'd8, 8'h02);
    chk("R6 later ack clears", trig_out, 8'h00);

    // R7, R8: restart
    wr(4'd7, 8'h08);
    pulse(8'h01);
    chk("R7 halt set", trig_out, 8'h01);
    pulse(8'h08);
    chk("R7 restart held off", trig_out, 8'h01);
    @(negedge clk);
    chk("R7 still held off", trig_out, 8'h01);
    wr(4'd8, 8'h01);
    chk("R7 restart after ack", trig_out, 8'h80);
    wr(4'd8, 8'hF8);
    chk("R8 ack bits ignored", trig_out, 8'h80);
    repeat (2) @(negedge clk);
    chk("R8 restart holds", trig_out, 8'h80);
    restarted = 1'b1;
    @(negedge clk); restarted = 1'b0;
    chk("R8 restart done", trig_out, 8'h00);

    // R9: software fire
    wr(4'd9, 8'h22);
    chk("R9 sw fire", trig_out, 8'h22);
    @(negedge clk);
    chk("R9 pulse ends sticky stays", trig_out, 8'h02);
    wr(4'd8, 8'h02);
    wr(4'd9, 8'h80);
    chk("R9 sw restart", trig_out, 8'h80);
    restarted = 1'b1;
    @(negedge clk); restarted = 1'b0;
    chk("R9 sw restart done", trig_out, 8'h00);

    // R1: reset clears pending state
    wr(4'd9, 8'h07);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset clears sticky", trig_out, 8'h00);
    pulse(8'h01);
    chk("R1 masks reset", trig_out, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule